// File: doc/BRIEF.md
# Multiplexed-bus SRAM slave decoder

This block is the device side of a 16-bit asynchronous memory whose address and data share one bus. A host first places the low address bits on the shared bus (with the high bits on separate upper address pins) while holding the address-valid strobe low. It then uses the chip select, output enable, write enable and two byte strobes to read or write a word or a single byte. The block samples all pins on a fast internal clock, so each pin change is seen one sample later. It decodes each sample into a bus mode, drives the shared bus during reads and commits byte-masked writes into a small internal word array.

The shared bus is not tri-stated inside the block. Read data leaves on `dq_out`, with a per-lane drive enable on `dq_drv`, and the surrounding logic (or the testbench) resolves the wire. A single control state machine decides the mode at every sample. Its states are ST_DESELECT (chip select high), ST_ADDR (address capture), ST_QUIET (selected but not driving), ST_READ, ST_WRITE (a write strobe overlap is open) and ST_DRAIN (a write ended on a byte-strobe release while chip select and write enable are still low). From ST_WRITE, the end-of-write transition goes to ST_DRAIN or to the mode of the current pins. From ST_DRAIN, the release transition goes to the mode of the current pins once chip select or write enable rises. Every other state moves to the mode of the current pins at each sample.

Top module: `mxs_slave`

## Requirements
- R1: A sample with `cs_n` high leaves `dq_drv` at 2'b00 on the next cycle, whatever the other pins show.
- R2: A sample with `cs_n` low, `adv_n` high and both `oe_n` and `we_n` high leaves `dq_drv` at 2'b00 on the next cycle.
- R3: A sample with `cs_n` low and `adv_n` low, outside an open write, latches `{addr_hi, dq_in}` as the 21-bit word address and leaves `dq_drv` at 2'b00 on the next cycle.
- R4: The latched address keeps its value while `adv_n` is high, however `dq_in` changes, until the next address sample.
- R5: A sample with `cs_n` low, `adv_n` high, `oe_n` low and `we_n` high is a read. On the next cycle, `dq_drv[0]` equals `~lb_n` and covers bits 7..0, `dq_drv[1]` equals `~ub_n` and covers bits 15..8, and the driven lanes of `dq_out` carry the stored word.
- R6: Lanes of `dq_out` whose bit in `dq_drv` is 0 read as zero.
- R7: A write opens on a sample with `cs_n` low, `adv_n` high, `we_n` low and at least one byte strobe low, even if `oe_n` is low. The lanes whose strobe is low at that sample are the write lanes, and the bus is not driven while the write is open.
- R8: An open write ends on the first sample where `cs_n` is high, `we_n` is high, or the strobe of any write lane is high. At that sample `dq_in` is stored into the write lanes only, and the other lane of the word is kept.
- R9: After a write ends on a strobe release while `cs_n` and `we_n` are still low, no new write opens until `cs_n` or `we_n` has gone high.
- R10: A read sampled in the same cycle a write ends returns the newly written data.
- R11: With ARRAY_AW address bits in the array, an address with any bit at or above ARRAY_AW set is out of range. Writes there change nothing, and reads there drive the selected lanes with zero.
- R12: After reset, `dq_drv` and `dq_out` are zero and every array word reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| adv_n | input | 1 | Address-valid strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| lb_n | input | 1 | Lower byte strobe (bits 7..0), active low |
| ub_n | input | 1 | Upper byte strobe (bits 15..8), active low |
| addr_hi | input | UPPER_W | Upper address pins |
| dq_in | input | 16 | Value seen on the shared address/data bus |
| dq_out | output | 16 | Read data toward the shared bus |
| dq_drv | output | 2 | Per-lane drive enable for the shared bus |

## Verification
On every cycle, the assertions check three things. The bus stays undriven after deselected, output-disabled and address samples. Any driven lanes match the byte strobes of a genuine read sample, and undriven lanes read zero. Inside the state machine, an open write always holds a non-empty lane set, and the drain state never reopens a write directly. What only the scenarios can show is the stored content itself: byte-lane merging, address hold across bus toggling, commit on a strobe release, read-after-write forwarding in the same sample, and the treatment of out-of-range addresses. These appear through the bench's behavioural reference memory and its directed reads.

// File: rtl/mxs_pkg.sv
package mxs_pkg;

    typedef enum logic [2:0] {
        ST_DESELECT = 3'd0,
        ST_ADDR     = 3'd1,
        ST_QUIET    = 3'd2,
        ST_READ     = 3'd3,
        ST_WRITE    = 3'd4,
        ST_DRAIN    = 3'd5
    } mxs_state_e;

    localparam int MXS_LANES  = 2;
    localparam int MXS_LANE_W = 8;
    localparam int MXS_BUS_W  = MXS_LANES * MXS_LANE_W;

endpackage

// File: rtl/mxs_ctrl_fsm.sv
module mxs_ctrl_fsm
    import mxs_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cs_n,
    input  logic                 adv_n,
    input  logic                 oe_n,
    input  logic                 we_n,
    input  logic [MXS_LANES-1:0] strb_n,
    output logic                 addr_load,
    output logic                 commit,
    output logic                 rd_en,
    output logic [MXS_LANES-1:0] rd_lanes,
    output logic [MXS_LANES-1:0] wr_lanes
);

    mxs_state_e           state_q;
    mxs_state_e           state_d;
    logic [MXS_LANES-1:0] lanes_q;
    logic                 wr_end;

    // Mode of the current pin sample when no write is open.
    function automatic mxs_state_e classify(
        input logic                 c_n,
        input logic                 a_n,
        input logic                 o_n,
        input logic                 w_n,
        input logic [MXS_LANES-1:0] s_n
    );
        mxs_state_e r;
        if (c_n) begin
            r = ST_DESELECT;
        end else if (!a_n) begin
            r = ST_ADDR;
        end else if (!w_n) begin
            r = (&s_n) ? ST_QUIET : ST_WRITE;
        end else if (!o_n) begin
            r = ST_READ;
        end else begin
            r = ST_QUIET;
        end
        return r;
    endfunction

    // Next-state logic
    always_comb begin
        state_d = state_q;
        wr_end  = 1'b0;
        unique case (state_q)
            ST_WRITE: begin
                wr_end = cs_n | we_n | ((lanes_q & strb_n) != '0);
                if (wr_end) begin
                    if (!cs_n && !we_n) begin
                        state_d = ST_DRAIN;
                    end else begin
                        state_d = classify(cs_n, adv_n, oe_n, we_n, strb_n);
                    end
                end
            end
            ST_DRAIN: begin
                if (cs_n || we_n) begin
                    state_d = classify(cs_n, adv_n, oe_n, we_n, strb_n);
                end
            end
            default: begin
                state_d = classify(cs_n, adv_n, oe_n, we_n, strb_n);
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_DESELECT;
            lanes_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q != ST_WRITE && state_d == ST_WRITE) begin
                lanes_q <= ~strb_n;
            end
        end
    end

    // Outputs
    always_comb begin
        addr_load = (state_d == ST_ADDR);
        commit    = wr_end;
        rd_en     = (state_d == ST_READ);
        rd_lanes  = ~strb_n;
        wr_lanes  = lanes_q;
    end

    assert_open_lanes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WRITE) |-> (lanes_q != '0));

    assert_drain_no_reopen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRAIN) |=> (state_q != ST_WRITE));

    assert_commit_closes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (state_q != ST_WRITE));

endmodule

// File: rtl/mxs_addr_latch.sv
module mxs_addr_latch #(
    parameter int BUS_W   = 16,
    parameter int UPPER_W = 5,
    localparam int ADDR_W = BUS_W + UPPER_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [UPPER_W-1:0] upper,
    input  logic [BUS_W-1:0]   bus,
    output logic [ADDR_W-1:0]  addr
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (load) begin
            addr <= {upper, bus};
        end
    end

endmodule

// File: rtl/mxs_word_array.sv
module mxs_word_array #(
    parameter int ADDR_W   = 21,
    parameter int ARRAY_AW = 6,
    parameter int BUS_W    = 16,
    parameter int LANE_W   = 8,
    localparam int LANES   = BUS_W / LANE_W,
    localparam int DEPTH   = 1 << ARRAY_AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_req,
    input  logic [LANES-1:0]  wr_lanes,
    input  logic [BUS_W-1:0]  wr_data,
    output logic [BUS_W-1:0]  rd_data
);

    logic [BUS_W-1:0]    mem_q [DEPTH];
    logic [ARRAY_AW-1:0] idx;
    logic                in_range;
    logic                wr_ok;
    logic [BUS_W-1:0]    merged;

    assign idx      = addr[ARRAY_AW-1:0];
    assign in_range = (addr[ADDR_W-1:ARRAY_AW] == '0);
    assign wr_ok    = wr_req & in_range;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else if (wr_ok) begin
            for (int l = 0; l < LANES; l++) begin
                if (wr_lanes[l]) begin
                    mem_q[idx][l*LANE_W +: LANE_W] <= wr_data[l*LANE_W +: LANE_W];
                end
            end
        end
    end

    // Forward a committing write to a read in the same sample
    for (genvar g = 0; g < LANES; g++) begin : g_fwd
        assign merged[g*LANE_W +: LANE_W] = (wr_ok && wr_lanes[g]) ?
            wr_data[g*LANE_W +: LANE_W] : mem_q[idx][g*LANE_W +: LANE_W];
    end

    assign rd_data = in_range ? merged : '0;

endmodule

// File: rtl/mxs_slave.sv
module mxs_slave
    import mxs_pkg::*;
#(
    parameter int UPPER_W  = 5,
    parameter int ARRAY_AW = 6,
    localparam int ADDR_W  = MXS_BUS_W + UPPER_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cs_n,
    input  logic                 adv_n,
    input  logic                 oe_n,
    input  logic                 we_n,
    input  logic                 lb_n,
    input  logic                 ub_n,
    input  logic [UPPER_W-1:0]   addr_hi,
    input  logic [MXS_BUS_W-1:0] dq_in,
    output logic [MXS_BUS_W-1:0] dq_out,
    output logic [MXS_LANES-1:0] dq_drv
);

    logic [MXS_LANES-1:0] strb_n;
    logic                 addr_load;
    logic                 commit;
    logic                 rd_en;
    logic [MXS_LANES-1:0] rd_lanes;
    logic [MXS_LANES-1:0] wr_lanes;
    logic [ADDR_W-1:0]    addr_q;
    logic [MXS_BUS_W-1:0] rd_word;
    logic [MXS_BUS_W-1:0] rd_mask;
    logic [MXS_BUS_W-1:0] drv_mask;
    logic [MXS_BUS_W-1:0] out_q;
    logic [MXS_LANES-1:0] drv_q;

    assign strb_n = {ub_n, lb_n};

    mxs_ctrl_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .adv_n     (adv_n),
        .oe_n      (oe_n),
        .we_n      (we_n),
        .strb_n    (strb_n),
        .addr_load (addr_load),
        .commit    (commit),
        .rd_en     (rd_en),
        .rd_lanes  (rd_lanes),
        .wr_lanes  (wr_lanes)
    );

    mxs_addr_latch #(
        .BUS_W   (MXS_BUS_W),
        .UPPER_W (UPPER_W)
    ) u_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (addr_load),
        .upper (addr_hi),
        .bus   (dq_in),
        .addr  (addr_q)
    );

    mxs_word_array #(
        .ADDR_W   (ADDR_W),
        .ARRAY_AW (ARRAY_AW),
        .BUS_W    (MXS_BUS_W),
        .LANE_W   (MXS_LANE_W)
    ) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (addr_q),
        .wr_req   (commit),
        .wr_lanes (wr_lanes),
        .wr_data  (dq_in),
        .rd_data  (rd_word)
    );

    for (genvar g = 0; g < MXS_LANES; g++) begin : g_mask
        assign rd_mask[g*MXS_LANE_W +: MXS_LANE_W]  = {MXS_LANE_W{rd_lanes[g]}};
        assign drv_mask[g*MXS_LANE_W +: MXS_LANE_W] = {MXS_LANE_W{dq_drv[g]}};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drv_q <= '0;
            out_q <= '0;
        end else if (rd_en) begin
            drv_q <= rd_lanes;
            out_q <= rd_word & rd_mask;
        end else begin
            drv_q <= '0;
            out_q <= '0;
        end
    end

    assign dq_drv = drv_q;
    assign dq_out = out_q;

    assert_desel_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (dq_drv == '0));

    assert_off_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && adv_n && oe_n && we_n) |=> (dq_drv == '0));

    assert_addr_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !adv_n) |=> (dq_drv == '0));

    assert_read_lanes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_drv != '0) |-> ($past(!cs_n && adv_n && !oe_n && we_n)
                            && (dq_drv == ~$past({ub_n, lb_n}))));

    assert_idle_lane_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((dq_out & ~drv_mask) == '0));

endmodule

// File: tb/mxs_slave_tb.sv
`timescale 1ns/1ps
module mxs_slave_tb;

    localparam int UPPER_W  = 5;
    localparam int ARRAY_AW = 6;
    localparam int DEPTH    = 1 << ARRAY_AW;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               cs_n = 1'b1, adv_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic               lb_n = 1'b1, ub_n = 1'b1;
    logic [UPPER_W-1:0] addr_hi = '0;
    logic [15:0]        dq_in = '0;
    logic [15:0]        dq_out;
    logic [1:0]         dq_drv;

    int checks = 0;
    int fails  = 0;
    bit started = 0;

    always #2 clk = ~clk;

    mxs_slave #(.UPPER_W(UPPER_W), .ARRAY_AW(ARRAY_AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .adv_n(adv_n), .oe_n(oe_n),
        .we_n(we_n), .lb_n(lb_n), .ub_n(ub_n), .addr_hi(addr_hi),
        .dq_in(dq_in), .dq_out(dq_out), .dq_drv(dq_drv)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [17:0] act, input logic [17:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Behavioural reference model
    logic [15:0] ref_mem [int];
    bit          m_wr = 0, m_drain = 0;
    logic [1:0]  m_lanes = '0;
    int unsigned m_addr = 0;
    logic [1:0]  exp_drv = '0;
    logic [15:0] exp_out = '0;
    string       exp_tag = "R12";

    function automatic logic [15:0] mem_get(input int unsigned a);
        if (a >= DEPTH) return 16'h0000;
        if (ref_mem.exists(int'(a))) return ref_mem[int'(a)];
        return 16'h0000;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_wr = 0; m_drain = 0; m_addr = 0;
            exp_drv = '0; exp_out = '0; exp_tag = "R12";
        end else begin
            logic [1:0]  s;
            logic [15:0] w;
            bit          done;
            s = {ub_n, lb_n};
            done = 0;
            exp_drv = '0;
            exp_out = '0;
            if (m_wr) begin
                exp_tag = "R8";
                if (cs_n || we_n || ((m_lanes & s) != 2'b00)) begin
                    if (m_addr < DEPTH) begin
                        w = mem_get(m_addr);
                        if (m_lanes[0]) w[7:0]  = dq_in[7:0];
                        if (m_lanes[1]) w[15:8] = dq_in[15:8];
                        ref_mem[int'(m_addr)] = w;
                    end
                    m_wr = 0;
                    if (!cs_n && !we_n) begin
                        m_drain = 1;
                        done = 1;
                    end
                end else begin
                    done = 1;
                end
            end else if (m_drain) begin
                exp_tag = "R9";
                if (cs_n || we_n) m_drain = 0;
                else done = 1;
            end
            if (!done) begin
                if (cs_n) begin
                    exp_tag = "R1";
                end else if (!adv_n) begin
                    exp_tag = "R3";
                    m_addr = {11'd0, addr_hi, dq_in};
                end else if (!we_n) begin
                    exp_tag = "R7";
                    if (s != 2'b11) begin
                        m_wr = 1;
                        m_lanes = ~s;
                    end
                end else if (!oe_n) begin
                    exp_tag = "R5";
                    exp_drv = ~s;
                    w = mem_get(m_addr);
                    exp_out = w & {{8{~s[1]}}, {8{~s[0]}}};
                end else begin
                    exp_tag = "R2";
                end
            end
        end
    end

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (started && rst_n) begin
            check({dq_drv, dq_out} == {exp_drv, exp_out},
                  {exp_tag, " model"}, {dq_drv, dq_out}, {exp_drv, exp_out});
        end
    end

    task automatic go_idle();
        @(negedge clk);
        cs_n = 1; adv_n = 1; oe_n = 1; we_n = 1; lb_n = 1; ub_n = 1;
    endtask

    task automatic addr_ph(input int unsigned a);
        @(negedge clk);
        cs_n = 0; adv_n = 0; oe_n = 1; we_n = 1; lb_n = 1; ub_n = 1;
        {addr_hi, dq_in} = a[20:0];
        @(negedge clk);
        adv_n = 1;
        dq_in = 16'hDEAD;
    endtask

    task automatic wr(input int unsigned a, input logic [15:0] d, input logic [1:0] s);
        addr_ph(a);
        we_n = 0; {ub_n, lb_n} = s; dq_in = d;
        @(negedge clk);
        @(negedge clk);
        we_n = 1;
        go_idle();
    endtask

    task automatic rd_cur(input logic [1:0] s, input logic [1:0] edrv,
                          input logic [15:0] eout, input string tag);
        oe_n = 0; we_n = 1; {ub_n, lb_n} = s;
        @(negedge clk);
        check({dq_drv, dq_out} == {edrv, eout}, tag, {dq_drv, dq_out}, {edrv, eout});
        go_idle();
    endtask

    task automatic rd(input int unsigned a, input logic [1:0] s, input logic [1:0] edrv,
                      input logic [15:0] eout, input string tag);
        addr_ph(a);
        rd_cur(s, edrv, eout, tag);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset state
        check({dq_drv, dq_out} == 18'h0, "R12 reset outputs", {dq_drv, dq_out}, 18'h0);
        rst_n = 1;
        started = 1;
        rd(5, 2'b00, 2'b11, 16'h0000, "R12 array cleared");

        // R5 / R8: word write and read
        wr(3, 16'hA5C3, 2'b00);
        rd(3, 2'b00, 2'b11, 16'hA5C3, "R5 word read");
        // R8: lower lane only
        wr(3, 16'h1177, 2'b10);
        rd(3, 2'b00, 2'b11, 16'hA577, "R8 lower lane merge");
        // R6: upper lane read only
        rd(3, 2'b01, 2'b10, 16'hA500, "R6 undriven lane zero");

        // R4: address held while bus toggles
        addr_ph(3);
        @(negedge clk); dq_in = 16'hFFFF;
        @(negedge clk); dq_in = 16'h0000;
        rd_cur(2'b00, 2'b11, 16'hA577, "R4 address hold");

        // R9: write ended by strobe release, drain without rewrite
        addr_ph(7);
        we_n = 0; lb_n = 0; ub_n = 0; dq_in = 16'h1234;
        @(negedge clk); ub_n = 1;
        @(negedge clk); dq_in = 16'hFFFF;
        @(negedge clk);
        @(negedge clk); we_n = 1;
        go_idle();
        rd(7, 2'b00, 2'b11, 16'h1234, "R9 no rewrite in drain");

        // R10: read in the sample that ends a write
        addr_ph(9);
        we_n = 0; lb_n = 0; ub_n = 0; dq_in = 16'hBEEF;
        @(negedge clk);
        we_n = 1; oe_n = 0;
        @(negedge clk);
        check({dq_drv, dq_out} == {2'b11, 16'hBEEF}, "R10 forward",
              {dq_drv, dq_out}, {2'b11, 16'hBEEF});
        go_idle();

        // R11: out-of-range address
        wr(32'h10005, 16'h5555, 2'b00);
        rd(32'h10005, 2'b00, 2'b11, 16'h0000, "R11 out of range read");
        rd(5, 2'b00, 2'b11, 16'h0000, "R11 no alias write");

        // R1: deselected with read pins
        @(negedge clk);
        cs_n = 1; adv_n = 1; oe_n = 0; we_n = 1; lb_n = 0; ub_n = 0;
        @(negedge clk);
        check(dq_drv == 2'b00, "R1 deselect quiet", {16'h0, dq_drv}, 18'h0);
        go_idle();

        // R2: output disabled
        addr_ph(3);
        oe_n = 1; we_n = 1; lb_n = 0; ub_n = 0;
        @(negedge clk);
        check(dq_drv == 2'b00, "R2 output disabled", {16'h0, dq_drv}, 18'h0);
        go_idle();

        // R3: address sample with output enable low
        @(negedge clk);
        cs_n = 0; adv_n = 0; oe_n = 0; we_n = 1; lb_n = 0; ub_n = 0; dq_in = 16'h0003;
        addr_hi = '0;
        @(negedge clk);
        check(dq_drv == 2'b00, "R3 address quiet", {16'h0, dq_drv}, 18'h0);
        go_idle();

        // R7: write enable wins over output enable, lower lane
        addr_ph(11);
        we_n = 0; oe_n = 0; lb_n = 0; ub_n = 1; dq_in = 16'h77AB;
        @(negedge clk);
        check(dq_drv == 2'b00, "R7 no drive while writing", {16'h0, dq_drv}, 18'h0);
        @(negedge clk); we_n = 1; oe_n = 1;
        go_idle();
        rd(11, 2'b00, 2'b11, 16'h00AB, "R7 lower lane written");

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule